// File: doc/BRIEF.md
# Serial Port Control Register with Address-Frame Wake-Up

This block holds the eight-bit control word of a serial port that runs in either asynchronous or clocked synchronous mode, and it contains the logic driven by that word. A CPU writes the word in one cycle and can read it back at any time. From the word the block derives three things. The first is the transmit and receive permissions. The second is the choice between the internal and the external bit clock, together with the role of the serial clock pin. The third is the gating of the interrupt requests that come from the transmitter and the receiver.

The receiver reports each finished frame with a one-cycle strobe. The strobe carries the frame's multiprocessor bit and its framing and overrun error indications. The block turns accepted strobes into flag-set pulses and interrupt pulses. When the multiprocessor enable bit is set, the receive path waits in a hunting state and drops every data frame. No flags are set and no interrupts are raised for those frames. A frame whose multiprocessor bit is 1 is delivered normally, and in the same cycle the hardware clears the enable bit. This lets one station on a shared line ignore all traffic until it is addressed.

The receive path has three named states, computed from the register every cycle:
- OFF: receive enable is 0.
- OPEN: receive enable is 1 and multiprocessor enable is 0.
- HUNT: both bits are 1.

There are four transitions:
- HUNT to OPEN, on an address frame (hardware clear), or on a CPU write of 0 to the enable bit.
- OPEN to HUNT, on a CPU write of 1 to the enable bit.
- Any state to OFF, when receive enable is written 0.
- OFF to OPEN or HUNT, when receive enable is written 1.

Top module: `sercfg_ctl`

## Requirements
- R1: After reset, all eight control bits read 0 and every interrupt and flag-set output is 0. The clock decode then gives the internal clock, with the pin as general I/O (code 00).
- R2: A CPU write stores all eight bits on the next clock edge, and `rd_data_o` returns them from the following cycle. The bit positions are: 7 transmit interrupt enable, 6 receive interrupt enable, 5 transmit enable, 4 receive enable, 3 multiprocessor enable, 2 transmit-end interrupt enable, 1 clock select high, 0 clock select low.
- R3: `irq_tx_empty_o` equals `tx_empty_i` AND bit 7, combinationally.
- R4: `irq_tx_end_o` equals `tx_end_i` AND bit 2, combinationally.
- R5: An accepted frame with no error gives a one-cycle `set_rx_full_o` pulse in the cycle after the strobe. When bit 6 is 1, it also gives an `irq_rx_full_o` pulse in that same cycle.
- R6: An accepted frame with a framing error or an overrun gives `set_frame_err_o` or `set_overrun_o` in the cycle after the strobe, and no receive-full pulse. When bit 6 is 1, it also gives an `irq_rx_err_o` pulse in that same cycle.
- R7: While bit 3 is 1 (HUNT), a frame with multiprocessor bit 0 sets no flag, raises no interrupt, and leaves bit 3 at 1.
- R8: In HUNT, a frame with multiprocessor bit 1 is delivered as in R5 and R6, and bit 3 reads 0 from the next cycle.
- R9: When a CPU write coincides with the hardware clear of bit 3, bit 3 becomes 0 and the other seven bits take the written value.
- R10: While bit 4 is 0, frame strobes set no flag, raise no interrupt, and do not change bit 3.
- R11: In asynchronous mode (`sync_mode_i`=0), the clock select field gives the following `sck_func_o` codes (00 GPIO, 01 clock out, 10 clock in) and `clk_ext_o` values:
  - 00: 00 and internal.
  - 01: 01 and internal.
  - 10 or 11: 10 and external.
- R12: In synchronous mode, select-high 0 gives code 01 with the internal clock, and select-high 1 gives code 10 with the external clock. Select-low has no effect.
- R13: `tx_en_o` follows bit 5 and `rx_en_o` follows bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 8 | CPU write data |
| rd_data_o | output | 8 | Current control word |
| sync_mode_i | input | 1 | 1 selects clocked synchronous mode |
| rx_done_i | input | 1 | One-cycle frame-finished strobe |
| rx_mpb_i | input | 1 | Multiprocessor bit of the frame |
| rx_fe_i | input | 1 | Frame had a framing error |
| rx_ovr_i | input | 1 | Frame caused an overrun |
| tx_empty_i | input | 1 | Transmit data register is empty |
| tx_end_i | input | 1 | Transmission has ended |
| tx_en_o | output | 1 | Transmitter permitted |
| rx_en_o | output | 1 | Receiver permitted |
| clk_ext_o | output | 1 | 1 selects the external bit clock |
| sck_func_o | output | 2 | Pin role: 00 GPIO, 01 clock out, 10 clock in |
| set_rx_full_o | output | 1 | Receive-full flag set pulse |
| set_frame_err_o | output | 1 | Framing-error flag set pulse |
| set_overrun_o | output | 1 | Overrun flag set pulse |
| irq_rx_full_o | output | 1 | Receive-full interrupt pulse |
| irq_rx_err_o | output | 1 | Receive-error interrupt pulse |
| irq_tx_empty_o | output | 1 | Transmit-empty interrupt request |
| irq_tx_end_o | output | 1 | Transmit-end interrupt request |

## Verification
Frames are sent in every receive state. Clean frames, framing-error frames and overrun frames are sent both with and without the receive interrupt enable. This separates the flag path from the interrupt gate, and the full pulse from the error pulses. In HUNT, frames with multiprocessor bit 0 and with bit 1 show the difference between a dropped frame and a wake-up frame, and show that the wake-up frame is still delivered. A write that lands in the same cycle as the wake-up shows which source wins for each bit. All select codes are applied in both modes, so the tests show which select bit is ignored in synchronous mode.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
    localparam int CR_W   = 8;
    localparam int B_TIE  = 7;
    localparam int B_RIE  = 6;
    localparam int B_TE   = 5;
    localparam int B_RE   = 4;
    localparam int B_MPIE = 3;
    localparam int B_TEIE = 2;
    localparam int B_CKH  = 1;
    localparam int B_CKL  = 0;

    typedef enum logic [1:0] {
        PIN_GPIO    = 2'b00,
        PIN_CLK_OUT = 2'b01,
        PIN_CLK_IN  = 2'b10
    } sck_fn_e;

    typedef enum logic [1:0] {
        RXM_OFF  = 2'b00,
        RXM_OPEN = 2'b01,
        RXM_HUNT = 2'b10
    } rx_mode_e;

    typedef struct packed {
        logic full;
        logic ferr;
        logic ovr;
    } rx_evt_t;
endpackage

// File: rtl/sercfg_reg.sv
module sercfg_reg
    import sercfg_pkg::*;
#(
    parameter logic [CR_W-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CR_W-1:0] wr_data,
    input  logic            mp_clr,
    output logic [CR_W-1:0] q
);
    logic [CR_W-1:0] d;

    // CPU write first, then the hardware clear overrides the enable bit only
    always_comb begin
        d = q;
        if (wr_en) d = wr_data;
        if (mp_clr) d[B_MPIE] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end

    assert_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mp_clr |=> !q[B_MPIE]);

    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mp_clr) |=> (!q[B_MPIE]
            && q[CR_W-1:B_MPIE+1] == $past(wr_data[CR_W-1:B_MPIE+1])
            && q[B_MPIE-1:0] == $past(wr_data[B_MPIE-1:0])));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !mp_clr) |=> $stable(q));
endmodule

// File: rtl/sercfg_clkdec.sv
module sercfg_clkdec
    import sercfg_pkg::*;
(
    input  logic       sync_mode,
    input  logic [1:0] cke,
    output logic       clk_ext,
    output sck_fn_e    sck_fn
);
    always_comb begin
        unique case ({sync_mode, cke})
            3'b000: begin clk_ext = 1'b0; sck_fn = PIN_GPIO;    end
            3'b001: begin clk_ext = 1'b0; sck_fn = PIN_CLK_OUT; end
            3'b010,
            3'b011: begin clk_ext = 1'b1; sck_fn = PIN_CLK_IN;  end
            3'b100,
            3'b101: begin clk_ext = 1'b0; sck_fn = PIN_CLK_OUT; end
            default: begin clk_ext = 1'b1; sck_fn = PIN_CLK_IN; end
        endcase
    end
endmodule

// File: rtl/sercfg_rxgate.sv
module sercfg_rxgate
    import sercfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic re,
    input  logic mpie,
    input  logic rie,
    input  logic rx_done,
    input  logic rx_mpb,
    input  logic rx_fe,
    input  logic rx_ovr,
    output logic mp_clr,
    output logic set_full,
    output logic set_fe,
    output logic set_ovr,
    output logic irq_full,
    output logic irq_err
);
    rx_mode_e mode;
    logic     accept;
    rx_evt_t  evt, evt_q;
    logic     irq_full_q, irq_err_q;

    // state follows the control bits every cycle
    always_comb begin
        if (!re)      mode = RXM_OFF;
        else if (mpie) mode = RXM_HUNT;
        else          mode = RXM_OPEN;
    end

    always_comb begin
        accept = 1'b0;
        mp_clr = 1'b0;
        unique case (mode)
            RXM_OFF:  accept = 1'b0;
            RXM_OPEN: accept = rx_done;
            RXM_HUNT: begin
                accept = rx_done && rx_mpb;
                mp_clr = rx_done && rx_mpb;
            end
            default:  accept = 1'b0;
        endcase
        evt.full = accept && !rx_fe && !rx_ovr;
        evt.ferr = accept && rx_fe;
        evt.ovr  = accept && rx_ovr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q      <= '0;
            irq_full_q <= 1'b0;
            irq_err_q  <= 1'b0;
        end else begin
            evt_q      <= evt;
            irq_full_q <= evt.full && rie;
            irq_err_q  <= (evt.ferr || evt.ovr) && rie;
        end
    end

    assign set_full = evt_q.full;
    assign set_fe   = evt_q.ferr;
    assign set_ovr  = evt_q.ovr;
    assign irq_full = irq_full_q;
    assign irq_err  = irq_err_q;

    assert_hunt_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (re && mpie && rx_done && !rx_mpb) |=> (!set_full && !set_fe && !set_ovr
            && !irq_full && !irq_err));

    assert_off_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!re && rx_done) |=> (!set_full && !set_fe && !set_ovr));

    assert_wake_deliver_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (re && mpie && rx_done && rx_mpb && !rx_fe && !rx_ovr) |=> set_full);

    assert_full_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full |-> set_full);

    assert_err_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (set_fe || set_ovr) && !set_full);
endmodule

// File: rtl/sercfg_txgate.sv
module sercfg_txgate (
    input  logic tie,
    input  logic teie,
    input  logic tx_empty,
    input  logic tx_end,
    output logic irq_empty,
    output logic irq_end
);
    assign irq_empty = tx_empty && tie;
    assign irq_end   = tx_end && teie;
endmodule

// File: rtl/sercfg_ctl.sv
module sercfg_ctl
    import sercfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       sync_mode_i,
    input  logic       rx_done_i,
    input  logic       rx_mpb_i,
    input  logic       rx_fe_i,
    input  logic       rx_ovr_i,
    input  logic       tx_empty_i,
    input  logic       tx_end_i,
    output logic       tx_en_o,
    output logic       rx_en_o,
    output logic       clk_ext_o,
    output logic [1:0] sck_func_o,
    output logic       set_rx_full_o,
    output logic       set_frame_err_o,
    output logic       set_overrun_o,
    output logic       irq_rx_full_o,
    output logic       irq_rx_err_o,
    output logic       irq_tx_empty_o,
    output logic       irq_tx_end_o
);
    logic [CR_W-1:0] cr;
    logic            mp_clr;
    sck_fn_e         sck_fn;

    sercfg_reg #(.RST_VAL('0)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
        .mp_clr(mp_clr), .q(cr)
    );

    sercfg_clkdec u_clk (
        .sync_mode(sync_mode_i), .cke(cr[B_CKH:B_CKL]),
        .clk_ext(clk_ext_o), .sck_fn(sck_fn)
    );

    sercfg_rxgate u_rx (
        .clk(clk), .rst_n(rst_n), .re(cr[B_RE]), .mpie(cr[B_MPIE]), .rie(cr[B_RIE]),
        .rx_done(rx_done_i), .rx_mpb(rx_mpb_i), .rx_fe(rx_fe_i), .rx_ovr(rx_ovr_i),
        .mp_clr(mp_clr), .set_full(set_rx_full_o), .set_fe(set_frame_err_o),
        .set_ovr(set_overrun_o), .irq_full(irq_rx_full_o), .irq_err(irq_rx_err_o)
    );

    sercfg_txgate u_tx (
        .tie(cr[B_TIE]), .teie(cr[B_TEIE]), .tx_empty(tx_empty_i), .tx_end(tx_end_i),
        .irq_empty(irq_tx_empty_o), .irq_end(irq_tx_end_o)
    );

    assign rd_data_o  = cr;
    assign tx_en_o    = cr[B_TE];
    assign rx_en_o    = cr[B_RE];
    assign sck_func_o = sck_fn;

    assert_txe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty_i && rd_data_o[7]) |-> irq_tx_empty_o);

    assert_tend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_end_o |-> (tx_end_i && rd_data_o[2]));

    assert_ext_pin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ext_o |-> (sck_func_o == 2'b10));

    assert_sync_pin_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_i && !clk_ext_o) |-> (sck_func_o == 2'b01));
endmodule

// File: tb/sim_sercfg_ctl.sv
module sim_sercfg_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       sync_mode_i = 1'b0;
    logic       rx_done_i = 1'b0, rx_mpb_i = 1'b0, rx_fe_i = 1'b0, rx_ovr_i = 1'b0;
    logic       tx_empty_i = 1'b0, tx_end_i = 1'b0;
    logic       tx_en_o, rx_en_o, clk_ext_o;
    logic [1:0] sck_func_o;
    logic       set_rx_full_o, set_frame_err_o, set_overrun_o;
    logic       irq_rx_full_o, irq_rx_err_o, irq_tx_empty_o, irq_tx_end_o;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    sercfg_ctl u0 (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic cpu_wr(input logic [7:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    // strobe one frame; on return the registered outputs show its result
    task automatic frame(input logic mpb, input logic fe, input logic ovr);
        rx_done_i = 1'b1; rx_mpb_i = mpb; rx_fe_i = fe; rx_ovr_i = ovr;
        @(posedge clk); #1;
        rx_done_i = 1'b0; rx_mpb_i = 1'b0; rx_fe_i = 1'b0; rx_ovr_i = 1'b0;
    endtask

    function automatic logic [7:0] rxo();
        return {3'b000, set_rx_full_o, set_frame_err_o, set_overrun_o,
                irq_rx_full_o, irq_rx_err_o};
    endfunction

    task automatic t_reset();
        check("R1 ctrl", rd_data_o, 8'h00);
        check("R1 rx outs", rxo(), 8'h00);
        check("R1 tx irqs", {irq_tx_empty_o, irq_tx_end_o}, 8'h00);
        check("R1 clock", {clk_ext_o, sck_func_o}, 8'h00);
    endtask

    task automatic t_rw();
        cpu_wr(8'hA5);
        check("R2 readback A5", rd_data_o, 8'hA5);
        check("R13 enables A5", {tx_en_o, rx_en_o}, 8'h02);
        cpu_wr(8'h5A);
        check("R2 readback 5A", rd_data_o, 8'h5A);
        check("R13 enables 5A", {tx_en_o, rx_en_o}, 8'h01);
        @(posedge clk); #1;
        check("R2 hold", rd_data_o, 8'h5A);
    endtask

    task automatic t_tx();
        cpu_wr(8'h00);
        tx_empty_i = 1'b1; tx_end_i = 1'b1; #1;
        check("R3 R4 gated off", {irq_tx_empty_o, irq_tx_end_o}, 8'h00);
        cpu_wr(8'h80); #1;
        check("R3 txe on", {irq_tx_empty_o, irq_tx_end_o}, 8'h02);
        cpu_wr(8'h04); #1;
        check("R4 tend on", {irq_tx_empty_o, irq_tx_end_o}, 8'h01);
        tx_end_i = 1'b0; #1;
        check("R4 source low", irq_tx_end_o, 1'b0);
        tx_empty_i = 1'b0;
    endtask

    task automatic t_rx_clean();
        cpu_wr(8'h50);
        frame(1'b0, 1'b0, 1'b0);
        check("R5 full+irq", rxo(), 8'h12);
        @(posedge clk); #1;
        check("R5 one pulse", rxo(), 8'h00);
        cpu_wr(8'h10);
        frame(1'b1, 1'b0, 1'b0);
        check("R5 no rie", rxo(), 8'h10);
    endtask

    task automatic t_rx_err();
        cpu_wr(8'h50);
        frame(1'b0, 1'b1, 1'b0);
        check("R6 fe+irq", rxo(), 8'h09);
        frame(1'b0, 1'b0, 1'b1);
        check("R6 ovr+irq", rxo(), 8'h05);
        cpu_wr(8'h10);
        frame(1'b0, 1'b1, 1'b1);
        check("R6 both no rie", rxo(), 8'h0C);
    endtask

    task automatic t_hunt();
        cpu_wr(8'h58);
        frame(1'b0, 1'b0, 1'b0);
        check("R7 drop clean", rxo(), 8'h00);
        frame(1'b0, 1'b1, 1'b1);
        check("R7 drop err", rxo(), 8'h00);
        check("R7 mpie kept", rd_data_o, 8'h58);
        frame(1'b1, 1'b0, 1'b0);
        check("R8 wake delivered", rxo(), 8'h12);
        check("R8 mpie cleared", rd_data_o, 8'h50);
        frame(1'b0, 1'b0, 1'b0);
        check("R8 open after wake", rxo(), 8'h12);
        cpu_wr(8'h58);
        frame(1'b1, 1'b1, 1'b0);
        check("R8 wake with fe", rxo(), 8'h09);
    endtask

    task automatic t_collide();
        cpu_wr(8'h18);
        wr_en_i = 1'b1; wr_data_i = 8'hFF;
        frame(1'b1, 1'b0, 1'b0);
        wr_en_i = 1'b0;
        check("R9 hw clear wins", rd_data_o, 8'hF7);
        check("R9 frame delivered", set_rx_full_o, 1'b1);
    endtask

    task automatic t_off();
        cpu_wr(8'h48);
        frame(1'b1, 1'b0, 1'b0);
        check("R10 no flags", rxo(), 8'h00);
        check("R10 mpie kept", rd_data_o, 8'h48);
        cpu_wr(8'h40);
        frame(1'b0, 1'b1, 1'b0);
        check("R10 off open", rxo(), 8'h00);
    endtask

    task automatic t_clk();
        sync_mode_i = 1'b0;
        cpu_wr(8'h00); check("R11 00", {clk_ext_o, sck_func_o}, 8'h00);
        cpu_wr(8'h01); check("R11 01", {clk_ext_o, sck_func_o}, 8'h01);
        cpu_wr(8'h02); check("R11 10", {clk_ext_o, sck_func_o}, 8'h06);
        cpu_wr(8'h03); check("R11 11", {clk_ext_o, sck_func_o}, 8'h06);
        sync_mode_i = 1'b1;
        cpu_wr(8'h00); check("R12 00", {clk_ext_o, sck_func_o}, 8'h01);
        cpu_wr(8'h01); check("R12 01", {clk_ext_o, sck_func_o}, 8'h01);
        cpu_wr(8'h02); check("R12 10", {clk_ext_o, sck_func_o}, 8'h06);
        cpu_wr(8'h03); check("R12 11", {clk_ext_o, sck_func_o}, 8'h06);
        sync_mode_i = 1'b0;
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_rw();
        t_tx();
        t_rx_clean();
        t_rx_err();
        t_hunt();
        t_collide();
        t_off();
        t_clk();
        finish_run();
    end
endmodule